// File: doc/BRIEF.md
# Direct-Mapped TLB with Victim Buffer

This block caches virtual-to-physical page translations for a core. The main array is direct-mapped: one entry per index, the index being the low bits of the virtual page number. Behind it sits a small fully associative victim buffer that catches entries recently pushed out of the main array. A client presents a virtual address and an access kind (load, store or instruction fetch) and receives a hit flag, the physical addend, an I/O flag and the I/O physical-address word of the page.

A lookup that hits the main array answers in one cycle. A main miss costs one more cycle, in which the victim buffer is searched. On a victim hit, that entry and the main entry at the index swap places, together with their I/O words. Only when both structures miss does the block raise a refill request and wait for the page walker to write the entry. When the write lands, the entry it displaces moves into the victim buffer and the main array is read again. A flush drops every translation at once.

Top module: `tlbv_top`

## Requirements
- R1: The main index is bits [PAGE_BITS +: log2(MAIN_ENTRIES)] of the virtual address. Pages with different indices stay resident side by side.
- R2: A tag matches when its page-number bits equal those of the address and its bit PAGE_BITS-1 (the invalid flag) is 0. A tag whose invalid flag is set never matches, in either array.
- R3: Every entry holds three tags. The access kind on `lk_kind` selects which one is compared: 0 = load, 1 = store, 2 = fetch, and 3 is treated as load.
- R4: A lookup accepted while `lk_ready` is high that hits the main array pulses `rsp_valid` with `rsp_hit`=1 on the first clock edge after acceptance, carrying the entry's addend and I/O word.
- R5: `rsp_io` is 1 when the matched tag has any nonzero bit below the page boundary, and 0 otherwise.
- R6: On a main miss, a victim hit answers on the second edge after acceptance. The hit entry and its I/O word go into the main array, and the displaced main entry takes its victim slot, so a repeat lookup hits the main array.
- R7: When several victim entries match, the one with the highest index wins.
- R8: `refill_req` rises on the second edge after acceptance, and only if both arrays miss. `refill_addr` is the page-aligned address. `lk_ready` stays low until the request is served.
- R9: One edge after `fill_valid` is taken, the main array is read again with the stored address, and `rsp_valid` pulses on the following edge. `rsp_hit` reflects whether the new entry matches.
- R10: A refill pushes the displaced main entry, if it is valid, into the victim buffer at a round-robin pointer that wraps and overwrites the oldest slot. An invalid displaced entry neither takes a slot nor moves the pointer.
- R11: `flush` invalidates every entry in both arrays, resets the round-robin pointer and returns the block to idle, abandoning a pending refill.
- R12: After reset, all entries are invalid, `lk_ready`=1, and `rsp_valid` and `refill_req` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Invalidate all entries and return to idle |
| lk_valid | input | 1 | Lookup request |
| lk_addr | input | VA_W | Virtual address of the lookup |
| lk_kind | input | 2 | Access kind: 0 load, 1 store, 2 fetch |
| lk_ready | output | 1 | Block is idle and takes a lookup |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_hit | output | 1 | Translation found |
| rsp_io | output | 1 | Page is an I/O page |
| rsp_addend | output | ADDEND_W | Physical addend of the page |
| rsp_ioaddr | output | IO_W | I/O physical-address word of the page |
| refill_req | output | 1 | Both arrays missed; waiting for the walker |
| refill_addr | output | VA_W | Page-aligned address to be walked |
| fill_valid | input | 1 | Walker writes the entry |
| fill_tag_load | input | VA_W | Load tag of the new entry |
| fill_tag_store | input | VA_W | Store tag of the new entry |
| fill_tag_fetch | input | VA_W | Fetch tag of the new entry |
| fill_addend | input | ADDEND_W | Addend of the new entry |
| fill_ioaddr | input | IO_W | I/O word of the new entry |

## Verification
The hardest state to reach from the ports is a victim buffer that holds two matching copies of one page, which is the only way to observe the search priority. The bench answers a refill for one page with the tags of another page at the same index, so the stale copy is pushed to the victim buffer. A later refill at that index pushes the second copy, and a lookup must then return the addend of the higher slot. Round-robin wrap and the rule that an empty main slot is not pushed are reached by long chains of refills at chosen indices, after which the survival or eviction of a specific page shows where the pointer stood.

// File: rtl/tlbv_pkg.sv
package tlbv_pkg;

  typedef enum logic [1:0] {
    ACC_LOAD  = 2'd0,
    ACC_STORE = 2'd1,
    ACC_FETCH = 2'd2
  } acc_e;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_VSCAN  = 2'd1,
    ST_WAIT   = 2'd2,
    ST_RELOOK = 2'd3
  } st_e;

  localparam int AW_MAX = 64;
  typedef logic [AW_MAX-1:0] aword_t;

  // Bits at or above the page boundary.
  function automatic aword_t page_mask(input int pb);
    return {AW_MAX{1'b1}} << pb;
  endfunction

  // Flag just below the page boundary that blocks any match.
  function automatic aword_t inval_bit(input int pb);
    return aword_t'(1) << (pb - 1);
  endfunction

  function automatic logic tag_match(input aword_t va, input aword_t tag, input int pb);
    return (va & page_mask(pb)) == (tag & (page_mask(pb) | inval_bit(pb)));
  endfunction

  function automatic logic tag_is_io(input aword_t tag, input int pb);
    return (tag & ~page_mask(pb)) != '0;
  endfunction

  function automatic aword_t pick_tag(input acc_e k, input aword_t t_ld,
                                      input aword_t t_st, input aword_t t_fx);
    case (k)
      ACC_STORE: return t_st;
      ACC_FETCH: return t_fx;
      default:   return t_ld;
    endcase
  endfunction

endpackage

// File: rtl/tlbv_main_array.sv
module tlbv_main_array #(
  parameter int ENTRIES  = 16,
  parameter int VA_W     = 32,
  parameter int ADDEND_W = 32,
  parameter int IO_W     = 32,
  localparam int IDX_W   = $clog2(ENTRIES)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clr,
  input  logic [IDX_W-1:0]    rd_idx,
  output logic                rd_vld,
  output logic [VA_W-1:0]     rd_tld,
  output logic [VA_W-1:0]     rd_tst,
  output logic [VA_W-1:0]     rd_tfx,
  output logic [ADDEND_W-1:0] rd_add,
  output logic [IO_W-1:0]     rd_io,
  input  logic                wr_en,
  input  logic [IDX_W-1:0]    wr_idx,
  input  logic [VA_W-1:0]     wr_tld,
  input  logic [VA_W-1:0]     wr_tst,
  input  logic [VA_W-1:0]     wr_tfx,
  input  logic [ADDEND_W-1:0] wr_add,
  input  logic [IO_W-1:0]     wr_io
);

  logic [ENTRIES-1:0]  vld;
  logic [VA_W-1:0]     t_ld [ENTRIES];
  logic [VA_W-1:0]     t_st [ENTRIES];
  logic [VA_W-1:0]     t_fx [ENTRIES];
  logic [ADDEND_W-1:0] add  [ENTRIES];
  logic [IO_W-1:0]     iow  [ENTRIES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     vld <= '0;
    else if (clr)   vld <= '0;
    else if (wr_en) vld[wr_idx] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (wr_en && !clr) begin
      t_ld[wr_idx] <= wr_tld;
      t_st[wr_idx] <= wr_tst;
      t_fx[wr_idx] <= wr_tfx;
      add[wr_idx]  <= wr_add;
      iow[wr_idx]  <= wr_io;
    end
  end

  assign rd_vld = vld[rd_idx];
  assign rd_tld = t_ld[rd_idx];
  assign rd_tst = t_st[rd_idx];
  assign rd_tfx = t_fx[rd_idx];
  assign rd_add = add[rd_idx];
  assign rd_io  = iow[rd_idx];

  // R11: a flush leaves no valid entry behind
  p_clr_empties_r11: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (vld == '0));

  // R9: a written entry is valid on the next cycle
  p_write_sets_valid_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !clr) |=> vld[$past(wr_idx)]);

endmodule

// File: rtl/tlbv_victim_buf.sv
module tlbv_victim_buf
  import tlbv_pkg::*;
#(
  parameter int ENTRIES   = 4,
  parameter int VA_W      = 32,
  parameter int PAGE_BITS = 12,
  parameter int ADDEND_W  = 32,
  parameter int IO_W      = 32,
  localparam int IDX_W    = $clog2(ENTRIES)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clr,
  input  logic [VA_W-1:0]     q_addr,
  input  acc_e                q_kind,
  output logic                hit,
  output logic [IDX_W-1:0]    hit_idx,
  output logic [VA_W-1:0]     h_tld,
  output logic [VA_W-1:0]     h_tst,
  output logic [VA_W-1:0]     h_tfx,
  output logic [ADDEND_W-1:0] h_add,
  output logic [IO_W-1:0]     h_io,
  input  logic                swap_en,
  input  logic                push_en,
  input  logic [VA_W-1:0]     in_tld,
  input  logic [VA_W-1:0]     in_tst,
  input  logic [VA_W-1:0]     in_tfx,
  input  logic [ADDEND_W-1:0] in_add,
  input  logic [IO_W-1:0]     in_io
);

  logic [ENTRIES-1:0]  vld;
  logic [VA_W-1:0]     t_ld [ENTRIES];
  logic [VA_W-1:0]     t_st [ENTRIES];
  logic [VA_W-1:0]     t_fx [ENTRIES];
  logic [ADDEND_W-1:0] add  [ENTRIES];
  logic [IO_W-1:0]     iow  [ENTRIES];
  logic [ENTRIES-1:0]  slot_match;
  logic [IDX_W-1:0]    rr_ptr;
  logic [IDX_W-1:0]    wr_idx;
  logic                wr_go;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign slot_match[g] = vld[g] &&
      tag_match(aword_t'(q_addr),
                pick_tag(q_kind, aword_t'(t_ld[g]), aword_t'(t_st[g]), aword_t'(t_fx[g])),
                PAGE_BITS);
  end

  // Later (higher) slots overwrite earlier ones: the top match wins.
  always_comb begin
    hit_idx = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (slot_match[i]) hit_idx = IDX_W'(i);
    end
  end

  assign hit   = |slot_match;
  assign h_tld = t_ld[hit_idx];
  assign h_tst = t_st[hit_idx];
  assign h_tfx = t_fx[hit_idx];
  assign h_add = add[hit_idx];
  assign h_io  = iow[hit_idx];

  assign wr_go  = (swap_en || push_en) && !clr;
  assign wr_idx = swap_en ? hit_idx : rr_ptr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld    <= '0;
      rr_ptr <= '0;
    end else if (clr) begin
      vld    <= '0;
      rr_ptr <= '0;
    end else begin
      if (wr_go) vld[wr_idx] <= 1'b1;
      if (push_en) rr_ptr <= (rr_ptr == IDX_W'(ENTRIES - 1)) ? '0 : rr_ptr + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_go) begin
      t_ld[wr_idx] <= in_tld;
      t_st[wr_idx] <= in_tst;
      t_fx[wr_idx] <= in_tfx;
      add[wr_idx]  <= in_add;
      iow[wr_idx]  <= in_io;
    end
  end

  // R6: a swap only ever targets a matching slot
  p_swap_needs_hit_r6: assert property (@(posedge clk) disable iff (!rst_n)
    swap_en |-> hit);

  // R10: swap and refill push never coincide
  p_swap_push_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(swap_en && push_en));

  // R10: each push advances the pointer by one slot, wrapping
  p_rr_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (push_en && !clr) |=> (rr_ptr == (($past(rr_ptr) == IDX_W'(ENTRIES - 1)) ? '0 : $past(rr_ptr) + 1'b1)));

  // R7: the chosen slot is the highest matching one
  p_top_match_r7: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> ((slot_match >> hit_idx) == 1));

endmodule

// File: rtl/tlbv_ctrl.sv
module tlbv_ctrl
  import tlbv_pkg::*;
#(
  parameter int VA_W      = 32,
  parameter int PAGE_BITS = 12,
  parameter int ADDEND_W  = 32,
  parameter int IO_W      = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                flush,
  input  logic                lk_valid,
  input  logic [VA_W-1:0]     lk_addr,
  input  acc_e                lk_kind,
  output logic                lk_ready,
  output logic [VA_W-1:0]     q_addr,
  output acc_e                q_kind,
  input  logic                m_hit,
  input  logic                m_io,
  input  logic [ADDEND_W-1:0] m_add,
  input  logic [IO_W-1:0]     m_iow,
  input  logic                v_hit,
  input  logic                v_io,
  input  logic [ADDEND_W-1:0] v_add,
  input  logic [IO_W-1:0]     v_iow,
  input  logic                fill_valid,
  output logic                swap_en,
  output logic                fill_en,
  output logic                refill_req,
  output logic [VA_W-1:0]     refill_addr,
  output logic                rsp_valid,
  output logic                rsp_hit,
  output logic                rsp_io,
  output logic [ADDEND_W-1:0] rsp_addend,
  output logic [IO_W-1:0]     rsp_ioaddr
);

  st_e             st, st_nx;
  logic [VA_W-1:0] cap_addr;
  acc_e            cap_kind;
  logic            accept;

  assign lk_ready    = (st == ST_IDLE);
  assign accept      = lk_ready && lk_valid && !flush;
  assign q_addr      = lk_ready ? lk_addr : cap_addr;
  assign q_kind      = lk_ready ? lk_kind : cap_kind;
  assign swap_en     = (st == ST_VSCAN) && v_hit && !flush;
  assign fill_en     = (st == ST_WAIT) && fill_valid && !flush;
  assign refill_req  = (st == ST_WAIT);
  assign refill_addr = {cap_addr[VA_W-1:PAGE_BITS], {PAGE_BITS{1'b0}}};

  always_comb begin
    st_nx = st;
    if (flush) st_nx = ST_IDLE;
    else begin
      case (st)
        ST_IDLE:   if (accept && !m_hit) st_nx = ST_VSCAN;
        ST_VSCAN:  st_nx = v_hit ? ST_IDLE : ST_WAIT;
        ST_WAIT:   if (fill_valid) st_nx = ST_RELOOK;
        default:   st_nx = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      cap_addr <= '0;
      cap_kind <= ACC_LOAD;
    end else begin
      st <= st_nx;
      if (accept) begin
        cap_addr <= lk_addr;
        cap_kind <= lk_kind;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid  <= 1'b0;
      rsp_hit    <= 1'b0;
      rsp_io     <= 1'b0;
      rsp_addend <= '0;
      rsp_ioaddr <= '0;
    end else begin
      rsp_valid <= 1'b0;
      if (!flush) begin
        if (accept && m_hit) begin
          rsp_valid  <= 1'b1;
          rsp_hit    <= 1'b1;
          rsp_io     <= m_io;
          rsp_addend <= m_add;
          rsp_ioaddr <= m_iow;
        end else if (swap_en) begin
          rsp_valid  <= 1'b1;
          rsp_hit    <= 1'b1;
          rsp_io     <= v_io;
          rsp_addend <= v_add;
          rsp_ioaddr <= v_iow;
        end else if (st == ST_RELOOK) begin
          rsp_valid  <= 1'b1;
          rsp_hit    <= m_hit;
          rsp_io     <= m_hit && m_io;
          rsp_addend <= m_hit ? m_add : '0;
          rsp_ioaddr <= m_hit ? m_iow : '0;
        end
      end
    end
  end

  // R4: a main hit answers on the next edge
  p_main_lat_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && m_hit) |=> (rsp_valid && rsp_hit));

  // R6: a victim hit answers on the next edge as a hit
  p_victim_lat_r6: assert property (@(posedge clk) disable iff (!rst_n)
    swap_en |=> (rsp_valid && rsp_hit));

  // R8: no walk when the victim buffer hits
  p_no_walk_on_vhit_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ((st == ST_VSCAN) && v_hit) |=> !refill_req);

  // R8: the block takes no lookup while a walk is pending
  p_busy_in_walk_r8: assert property (@(posedge clk) disable iff (!rst_n)
    refill_req |-> !lk_ready);

  // R9: response two edges after the fill is taken
  p_relook_lat_r9: assert property (@(posedge clk) disable iff (!rst_n || flush)
    fill_en |=> (!rsp_valid ##1 rsp_valid));

  // R11: a flush returns to idle
  p_flush_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (lk_ready && !refill_req && !rsp_valid));

endmodule

// File: rtl/tlbv_top.sv
module tlbv_top
  import tlbv_pkg::*;
#(
  parameter int VA_W           = 32,
  parameter int PAGE_BITS      = 12,
  parameter int MAIN_ENTRIES   = 16,
  parameter int VICTIM_ENTRIES = 4,
  parameter int ADDEND_W       = 32,
  parameter int IO_W           = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                flush,
  input  logic                lk_valid,
  input  logic [VA_W-1:0]     lk_addr,
  input  logic [1:0]          lk_kind,
  output logic                lk_ready,
  output logic                rsp_valid,
  output logic                rsp_hit,
  output logic                rsp_io,
  output logic [ADDEND_W-1:0] rsp_addend,
  output logic [IO_W-1:0]     rsp_ioaddr,
  output logic                refill_req,
  output logic [VA_W-1:0]     refill_addr,
  input  logic                fill_valid,
  input  logic [VA_W-1:0]     fill_tag_load,
  input  logic [VA_W-1:0]     fill_tag_store,
  input  logic [VA_W-1:0]     fill_tag_fetch,
  input  logic [ADDEND_W-1:0] fill_addend,
  input  logic [IO_W-1:0]     fill_ioaddr
);

  localparam int MIDX_W = $clog2(MAIN_ENTRIES);
  localparam int VIDX_W = $clog2(VICTIM_ENTRIES);

  logic [VA_W-1:0]     q_addr;
  acc_e                q_kind;
  logic [MIDX_W-1:0]   m_idx;
  logic                m_vld, m_hit, m_io;
  logic [VA_W-1:0]     m_tld, m_tst, m_tfx;
  logic [ADDEND_W-1:0] m_add;
  logic [IO_W-1:0]     m_iow;
  aword_t              m_tag;
  logic                v_hit, v_io;
  logic [VIDX_W-1:0]   v_idx;
  logic [VA_W-1:0]     v_tld, v_tst, v_tfx;
  logic [ADDEND_W-1:0] v_add;
  logic [IO_W-1:0]     v_iow;
  aword_t              v_tag;
  logic                swap_en, fill_en, push_en, mw_en;
  logic [VA_W-1:0]     mw_tld, mw_tst, mw_tfx;
  logic [ADDEND_W-1:0] mw_add;
  logic [IO_W-1:0]     mw_io;

  assign m_idx = q_addr[PAGE_BITS +: MIDX_W];
  assign m_tag = pick_tag(q_kind, aword_t'(m_tld), aword_t'(m_tst), aword_t'(m_tfx));
  assign m_hit = m_vld && tag_match(aword_t'(q_addr), m_tag, PAGE_BITS);
  assign m_io  = tag_is_io(m_tag, PAGE_BITS);
  assign v_tag = pick_tag(q_kind, aword_t'(v_tld), aword_t'(v_tst), aword_t'(v_tfx));
  assign v_io  = tag_is_io(v_tag, PAGE_BITS);

  // Main array is written by a swap (victim entry) or by a refill.
  assign mw_en   = swap_en || fill_en;
  assign mw_tld  = swap_en ? v_tld : fill_tag_load;
  assign mw_tst  = swap_en ? v_tst : fill_tag_store;
  assign mw_tfx  = swap_en ? v_tfx : fill_tag_fetch;
  assign mw_add  = swap_en ? v_add : fill_addend;
  assign mw_io   = swap_en ? v_iow : fill_ioaddr;
  assign push_en = fill_en && m_vld;

  tlbv_ctrl #(
    .VA_W(VA_W), .PAGE_BITS(PAGE_BITS), .ADDEND_W(ADDEND_W), .IO_W(IO_W)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .lk_valid(lk_valid), .lk_addr(lk_addr), .lk_kind(acc_e'(lk_kind)),
    .lk_ready(lk_ready), .q_addr(q_addr), .q_kind(q_kind),
    .m_hit(m_hit), .m_io(m_io), .m_add(m_add), .m_iow(m_iow),
    .v_hit(v_hit), .v_io(v_io), .v_add(v_add), .v_iow(v_iow),
    .fill_valid(fill_valid), .swap_en(swap_en), .fill_en(fill_en),
    .refill_req(refill_req), .refill_addr(refill_addr),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_io(rsp_io),
    .rsp_addend(rsp_addend), .rsp_ioaddr(rsp_ioaddr)
  );

  tlbv_main_array #(
    .ENTRIES(MAIN_ENTRIES), .VA_W(VA_W), .ADDEND_W(ADDEND_W), .IO_W(IO_W)
  ) u_main (
    .clk(clk), .rst_n(rst_n), .clr(flush),
    .rd_idx(m_idx), .rd_vld(m_vld), .rd_tld(m_tld), .rd_tst(m_tst),
    .rd_tfx(m_tfx), .rd_add(m_add), .rd_io(m_iow),
    .wr_en(mw_en), .wr_idx(m_idx), .wr_tld(mw_tld), .wr_tst(mw_tst),
    .wr_tfx(mw_tfx), .wr_add(mw_add), .wr_io(mw_io)
  );

  tlbv_victim_buf #(
    .ENTRIES(VICTIM_ENTRIES), .VA_W(VA_W), .PAGE_BITS(PAGE_BITS),
    .ADDEND_W(ADDEND_W), .IO_W(IO_W)
  ) u_victim (
    .clk(clk), .rst_n(rst_n), .clr(flush),
    .q_addr(q_addr), .q_kind(q_kind),
    .hit(v_hit), .hit_idx(v_idx), .h_tld(v_tld), .h_tst(v_tst),
    .h_tfx(v_tfx), .h_add(v_add), .h_io(v_iow),
    .swap_en(swap_en), .push_en(push_en),
    .in_tld(m_tld), .in_tst(m_tst), .in_tfx(m_tfx), .in_add(m_add), .in_io(m_iow)
  );

  // R5: an I/O response is always a hit
  p_io_is_hit_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_io) |-> rsp_hit);

  // R8: a walk is requested only after the victim search found nothing
  p_walk_after_double_miss_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(refill_req) |-> $past(!v_hit));

  // R6: the victim slot index is used only when the buffer hits
  p_vidx_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !v_hit |-> (v_idx == '0));

endmodule

// File: tb/tb_tlbv_top.sv
module tb_tlbv_top;

  localparam int VA_W = 32;
  localparam int PB   = 12;
  localparam int ME   = 4;
  localparam int VE   = 4;

  logic        clk = 1'b0, rst_n = 1'b0, flush = 1'b0;
  logic        lk_valid = 1'b0;
  logic [31:0] lk_addr = '0;
  logic [1:0]  lk_kind = '0;
  logic        fill_valid = 1'b0;
  logic [31:0] f_ld = '0, f_st = '0, f_fx = '0, f_add = '0, f_io = '0;
  logic        lk_ready, rsp_valid, rsp_hit, rsp_io, refill_req;
  logic [31:0] rsp_addend, rsp_ioaddr, refill_addr;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  int          r_lat;
  bit          r_hit, r_io, r_ref, r_rdy;
  logic [31:0] r_add, r_iow, r_raddr;

  always #2 clk = ~clk;

  tlbv_top #(.VA_W(VA_W), .PAGE_BITS(PB), .MAIN_ENTRIES(ME), .VICTIM_ENTRIES(VE),
             .ADDEND_W(32), .IO_W(32)) dut (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .lk_valid(lk_valid), .lk_addr(lk_addr), .lk_kind(lk_kind), .lk_ready(lk_ready),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_io(rsp_io),
    .rsp_addend(rsp_addend), .rsp_ioaddr(rsp_ioaddr),
    .refill_req(refill_req), .refill_addr(refill_addr),
    .fill_valid(fill_valid), .fill_tag_load(f_ld), .fill_tag_store(f_st),
    .fill_tag_fetch(f_fx), .fill_addend(f_add), .fill_ioaddr(f_io)
  );

  function automatic logic [31:0] mk_tag(input logic [31:0] pg, input bit io, input bit inv);
    return (pg & 32'hFFFF_F000) | (io ? 32'h4 : 32'h0) | (inv ? 32'h800 : 32'h0);
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic flush_all();
    @(negedge clk); flush = 1'b1;
    @(negedge clk); flush = 1'b0;
  endtask

  // One lookup; optionally serves a refill with the given entry.
  task automatic access(input logic [31:0] a, input logic [1:0] k, input bit fill_it,
                        input logic [31:0] tld, input logic [31:0] tst, input logic [31:0] tfx,
                        input logic [31:0] add, input logic [31:0] iow);
    int n;
    r_lat = -1; r_hit = 0; r_io = 0; r_ref = 0; r_rdy = 1; r_add = '0; r_iow = '0; r_raddr = '0;
    @(negedge clk); lk_valid = 1'b1; lk_addr = a; lk_kind = k;
    @(negedge clk); lk_valid = 1'b0;
    n = 1;
    while (n < 40) begin
      if (rsp_valid) begin
        r_lat = n; r_hit = rsp_hit; r_io = rsp_io; r_add = rsp_addend; r_iow = rsp_ioaddr;
        return;
      end
      if (refill_req) begin
        r_ref = 1; r_raddr = refill_addr; r_rdy = lk_ready;
        if (!fill_it) begin r_lat = n; return; end
        fill_valid = 1'b1; f_ld = tld; f_st = tst; f_fx = tfx; f_add = add; f_io = iow;
        @(negedge clk); fill_valid = 1'b0; n++;
        continue;
      end
      @(negedge clk); n++;
    end
  endtask

  task automatic fill_page(input logic [31:0] pg, input logic [31:0] add, input logic [31:0] iow,
                           input string req);
    access(pg, 2'd0, 1, mk_tag(pg,0,0), mk_tag(pg,0,0), mk_tag(pg,0,0), add, iow);
    chk(r_ref && r_lat == 4 && r_hit && r_add == add, req, "refill then hit", r_add, add);
  endtask

  task automatic expect_hit(input logic [31:0] a, input logic [1:0] k, input int lat,
                            input logic [31:0] add, input string req);
    access(a, k, 0, '0, '0, '0, '0, '0);
    chk(r_lat == lat && r_hit && !r_ref, req, "latency", 32'(r_lat), 32'(lat));
    chk(r_add == add, req, "addend", r_add, add);
  endtask

  task automatic t_reset();
    chk(lk_ready == 1'b1, "R12", "ready after reset", 32'(lk_ready), 32'd1);
    chk(rsp_valid == 1'b0 && refill_req == 1'b0, "R12", "quiet after reset",
        {30'd0, rsp_valid, refill_req}, 32'd0);
  endtask

  task automatic t_cold();
    access(32'h0000_1234, 2'd0, 1, mk_tag(32'h1000,0,0), mk_tag(32'h1000,0,0),
           mk_tag(32'h1000,0,0), 32'hA000_0001, 32'h11);
    chk(r_ref, "R8", "refill requested on cold miss", 32'(r_ref), 32'd1);
    chk(r_raddr == 32'h1000, "R8", "refill address page aligned", r_raddr, 32'h1000);
    chk(!r_rdy, "R8", "not ready while walking", 32'(r_rdy), 32'd0);
    chk(r_lat == 4 && r_hit, "R9", "reread after fill", 32'(r_lat), 32'd4);
    chk(r_add == 32'hA000_0001, "R9", "fill addend", r_add, 32'hA000_0001);
    expect_hit(32'h0000_1FF8, 2'd0, 1, 32'hA000_0001, "R4");
    chk(r_iow == 32'h11 && !r_io, "R4", "io word on plain page", r_iow, 32'h11);
    fill_page(32'h2000, 32'hA000_0002, 32'h22, "R1");
    expect_hit(32'h1000, 2'd0, 1, 32'hA000_0001, "R1");
    expect_hit(32'h2000, 2'd0, 1, 32'hA000_0002, "R1");
  endtask

  task automatic t_kinds();
    flush_all();
    access(32'h3000, 2'd0, 1, mk_tag(32'h3000,0,0), mk_tag(32'h3000,0,1),
           mk_tag(32'h3000,1,0), 32'hA000_0003, 32'h33);
    chk(r_lat == 4 && r_hit, "R3", "load tag after fill", 32'(r_lat), 32'd4);
    expect_hit(32'h3010, 2'd0, 1, 32'hA000_0003, "R3");
    chk(!r_io, "R5", "load tag not io", 32'(r_io), 32'd0);
    expect_hit(32'h3020, 2'd2, 1, 32'hA000_0003, "R3");
    chk(r_io && r_iow == 32'h33, "R5", "fetch tag marks io", r_iow, 32'h33);
    expect_hit(32'h3030, 2'd3, 1, 32'hA000_0003, "R3");
    access(32'h3040, 2'd1, 0, '0, '0, '0, '0, '0);
    chk(r_ref && r_lat == 2, "R2", "invalid store tag misses", 32'(r_lat), 32'd2);
    flush_all();
  endtask

  task automatic t_victim();
    flush_all();
    fill_page(32'h1000, 32'hA1, 32'h11, "R6");
    fill_page(32'h5000, 32'hA5, 32'h55, "R6");
    expect_hit(32'h1000, 2'd0, 2, 32'hA1, "R6");
    chk(r_iow == 32'h11, "R6", "io word travels with entry", r_iow, 32'h11);
    expect_hit(32'h1000, 2'd0, 1, 32'hA1, "R6");
    expect_hit(32'h5000, 2'd0, 2, 32'hA5, "R6");
    chk(r_iow == 32'h55, "R6", "displaced io word", r_iow, 32'h55);
  endtask

  task automatic t_priority();
    flush_all();
    fill_page(32'h1000, 32'hB0, 32'h0, "R7");
    access(32'h5000, 2'd0, 1, mk_tag(32'h1000,0,0), mk_tag(32'h1000,0,0),
           mk_tag(32'h1000,0,0), 32'hB1, 32'h0);
    chk(r_lat == 4 && !r_hit, "R9", "reread of mismatching fill misses", 32'(r_hit), 32'd0);
    fill_page(32'h9000, 32'hB9, 32'h0, "R7");
    expect_hit(32'h1000, 2'd0, 2, 32'hB1, "R7");
  endtask

  task automatic t_rr();
    flush_all();
    for (int i = 0; i < 6; i++) fill_page(32'h4000 * (i + 1), 32'hC0 + i, 32'h0, "R10");
    expect_hit(32'h8000, 2'd0, 2, 32'hC1, "R10");
    access(32'h4000, 2'd0, 0, '0, '0, '0, '0, '0);
    chk(r_ref && r_lat == 2, "R10", "oldest slot overwritten on wrap", 32'(r_ref), 32'd1);
    flush_all();
    chk(lk_ready && !refill_req, "R11", "flush abandons walk",
        {30'd0, lk_ready, refill_req}, 32'd2);
    access(32'h8000, 2'd0, 0, '0, '0, '0, '0, '0);
    chk(r_ref && r_lat == 2, "R11", "flushed entries miss in both arrays", 32'(r_lat), 32'd2);
    flush_all();
  endtask

  task automatic t_empty_slot();
    flush_all();
    for (int i = 0; i < 4; i++) begin
      fill_page(32'h10000 + 32'h1000 * i, 32'hD0 + i, 32'h0, "R10");
      fill_page(32'h20000 + 32'h1000 * i, 32'hE0 + i, 32'h0, "R10");
    end
    expect_hit(32'h10000, 2'd0, 2, 32'hD0, "R10");
    expect_hit(32'h11000, 2'd0, 2, 32'hD1, "R10");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_cold();
    t_kinds();
    t_victim();
    t_priority();
    t_rr();
    t_empty_slot();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog run did not complete actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule